// File: doc/BRIEF.md
# NAND Chunk Single-Error-Correcting Parity Engine

This block builds a 24-bit single-error-correcting parity code over a 512-byte chunk while the bytes pass to or from a NAND device. Each byte carries a 12-bit bit position, made of a 9-bit byte index and a 3-bit bit-in-byte index. Every data bit equal to one folds that position into an upper 12-bit half and the complement of the position into a lower 12-bit half. The packed code is inverted on output. An erased chunk, which reads as all ones, therefore produces the same code as an erased spare area, and it checks clean.

A separate accumulation context is kept for each chipselect, and `cs_i` selects the active one. A start pulse clears the selected context. When a write finishes, the host takes `code_o` and stores its three bytes, low byte first. When a read finishes, the host pulses `chk_i` with the stored code. One cycle later the block reports whether the chunk is clean, has one bad data bit (with the byte and bit to flip), has one bad bit in the stored code only, or cannot be corrected. The block does not buffer the data and does not apply the fix.

Top module: `nand_ecc1_engine`

## Requirements
- R1: After reset every context is empty. `code_o` reads 24'hFFFFFF and `chk_done_o` is low.
- R2: A one bit at bit b of the byte with index n folds position p = {n[8:0], b[2:0]} into the upper half (hi ^= p) and ~p into the lower half (lo ^= ~p). `code_o` is ~{hi, lo}, so hi sits in bits 23:12 and lo in bits 11:0. Bits 7:0 form the first stored byte. An all-ones chunk gives 24'hFFFFFF.
- R3: The byte index is the number of bytes the selected context has accepted since it was cleared. Bytes offered after the 512th are ignored.
- R4: `start_i` clears the selected context, and `code_o` reads 24'hFFFFFF in the next cycle. A byte strobed in the same cycle as `start_i` is discarded and does not advance the index.
- R5: Bytes update only the context that `cs_i` selects. With no strobe and no start, the code of a context does not change.
- R6: `chk_i` compares `code_o` with `stored_code_i` at that clock edge, forming diff = code XOR stored. In the next cycle `chk_done_o` is high for exactly one cycle with the result. Status codes: 0 clean, 1 data bit, 2 code bit, 3 uncorrectable.
- R7: A diff of zero gives status 0, with `err_byte_o` and `err_bit_o` both zero.
- R8: If diff[23:12] XOR diff[11:0] equals 12'hFFF and the byte index is inside the chunk, the status is 1, `err_byte_o` = diff[23:15] and `err_bit_o` = diff[14:12].
- R9: A diff with exactly one bit set gives status 2, meaning the data needs no change.
- R10: Every other diff, and a correctable pattern whose byte index falls outside the chunk, gives status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 2 | Chipselect context index |
| start_i | input | 1 | Clear the selected context |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| chk_i | input | 1 | Compare request |
| stored_code_i | input | 24 | Code read back from the spare area |
| code_o | output | 24 | Inverted packed code of the selected context |
| chk_done_o | output | 1 | Compare result valid |
| status_o | output | 2 | Compare outcome |
| err_byte_o | output | 9 | Byte index to flip |
| err_bit_o | output | 3 | Bit index to flip |

## Verification
Context isolation is the hardest condition to reach from the ports. It only appears when one chunk is split around a full chunk sent to another chipselect. The stimulus starts two contexts, feeds the first hundred bytes of one chunk, switches to the other chipselect for a whole 512-byte chunk, then finishes the first chunk. Both codes must match the values computed from each chunk alone. The error cases reuse a recorded good code while flipping chosen data bits, including the first and last byte of the chunk.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_DATA   = 2'd1,
        ST_CODE   = 2'd2,
        ST_UNCORR = 2'd3
    } ecc_status_e;

endpackage

// File: rtl/nand_ecc1_bitfold.sv
module nand_ecc1_bitfold #(
    parameter int BI_W  = 9,
    parameter int POS_W = BI_W + 3
) (
    input  logic [BI_W-1:0]  byte_idx_i,
    input  logic [7:0]       data_i,
    output logic [POS_W-1:0] hi_fold_o,
    output logic [POS_W-1:0] lo_fold_o
);
    always_comb begin
        hi_fold_o = '0;
        lo_fold_o = '0;
        for (int b = 0; b < 8; b++) begin
            if (data_i[b]) begin
                hi_fold_o = hi_fold_o ^ {byte_idx_i, 3'(b)};
                lo_fold_o = lo_fold_o ^ ~{byte_idx_i, 3'(b)};
            end
        end
    end
endmodule

// File: rtl/nand_ecc1_classify.sv
module nand_ecc1_classify
    import nand_ecc1_pkg::*;
#(
    parameter int CHUNK_BYTES = 512,
    parameter int BI_W        = 9,
    parameter int POS_W       = BI_W + 3,
    parameter int CODE_W      = 2 * POS_W
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output ecc_status_e       status_o,
    output logic [BI_W-1:0]   byte_o,
    output logic [2:0]        bit_o
);
    logic [CODE_W-1:0] diff;
    logic [POS_W-1:0]  halves;
    logic [BI_W-1:0]   idx;

    always_comb begin
        diff     = calc_i ^ stored_i;
        halves   = diff[CODE_W-1:POS_W] ^ diff[POS_W-1:0];
        idx      = diff[CODE_W-1:POS_W+3];
        status_o = ST_UNCORR;
        byte_o   = '0;
        bit_o    = '0;
        if (diff == '0) begin
            status_o = ST_CLEAN;
        end else if (&halves) begin
            if ({1'b0, idx} < (BI_W+1)'(CHUNK_BYTES)) begin
                status_o = ST_DATA;
                byte_o   = idx;
                bit_o    = diff[POS_W+2:POS_W];
            end
        end else if ($onehot(diff)) begin
            status_o = ST_CODE;
        end
    end
endmodule

// File: rtl/nand_ecc1_engine.sv
module nand_ecc1_engine
    import nand_ecc1_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int CHUNK_BYTES = 512,
    localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BI_W       = $clog2(CHUNK_BYTES),
    localparam int POS_W      = BI_W + 3,
    localparam int CODE_W     = 2 * POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CS_W-1:0]   cs_i,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              chk_i,
    input  logic [CODE_W-1:0] stored_code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              chk_done_o,
    output logic [1:0]        status_o,
    output logic [BI_W-1:0]   err_byte_o,
    output logic [2:0]        err_bit_o
);
    localparam int CNT_W = BI_W + 1;

    typedef struct packed {
        logic [POS_W-1:0] hi;
        logic [POS_W-1:0] lo;
        logic [CNT_W-1:0] cnt;
    } ctx_t;

    typedef struct packed {
        ctx_t [NUM_CS-1:0] ctx;
        logic              done;
        ecc_status_e       status;
        logic [BI_W-1:0]   ebyte;
        logic [2:0]        ebit;
    } state_t;

    state_t st_d, st_q;

    logic [POS_W-1:0]  hi_fold, lo_fold;
    logic [CODE_W-1:0] code_sel;
    ecc_status_e       cls_status;
    logic [BI_W-1:0]   cls_byte;
    logic [2:0]        cls_bit;

    assign code_sel = ~{st_q.ctx[cs_i].hi, st_q.ctx[cs_i].lo};

    nand_ecc1_bitfold #(.BI_W(BI_W), .POS_W(POS_W)) u_fold (
        .byte_idx_i (st_q.ctx[cs_i].cnt[BI_W-1:0]),
        .data_i     (byte_i),
        .hi_fold_o  (hi_fold),
        .lo_fold_o  (lo_fold)
    );

    nand_ecc1_classify #(
        .CHUNK_BYTES (CHUNK_BYTES),
        .BI_W        (BI_W),
        .POS_W       (POS_W),
        .CODE_W      (CODE_W)
    ) u_cls (
        .calc_i   (code_sel),
        .stored_i (stored_code_i),
        .status_o (cls_status),
        .byte_o   (cls_byte),
        .bit_o    (cls_bit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.ctx[cs_i] = '0;
        end else if (byte_vld_i && (st_q.ctx[cs_i].cnt < CNT_W'(CHUNK_BYTES))) begin
            st_d.ctx[cs_i].hi  = st_q.ctx[cs_i].hi ^ hi_fold;
            st_d.ctx[cs_i].lo  = st_q.ctx[cs_i].lo ^ lo_fold;
            st_d.ctx[cs_i].cnt = st_q.ctx[cs_i].cnt + 1'b1;
        end
        if (chk_i) begin
            st_d.done   = 1'b1;
            st_d.status = cls_status;
            st_d.ebyte  = cls_byte;
            st_d.ebit   = cls_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o     = code_sel;
    assign chk_done_o = st_q.done;
    assign status_o   = st_q.status;
    assign err_byte_o = st_q.ebyte;
    assign err_bit_o  = st_q.ebit;
endmodule

// File: rtl/nand_ecc1_engine_chk.sv
module nand_ecc1_engine_chk #(
    parameter int CS_W   = 2,
    parameter int BI_W   = 9,
    parameter int CODE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CS_W-1:0]   cs_i,
    input logic              start_i,
    input logic              byte_vld_i,
    input logic              chk_i,
    input logic [CODE_W-1:0] code_o,
    input logic              chk_done_o,
    input logic [1:0]        status_o,
    input logic [BI_W-1:0]   err_byte_o,
    input logic [2:0]        err_bit_o
);
    AST_DONE_AFTER_CHK: assert property (@(posedge clk) disable iff (!rst_n)
        chk_i |=> chk_done_o); // R6
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_i |=> !chk_done_o); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cs_i != $past(cs_i)) || (code_o == '1)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !byte_vld_i) ##1 (cs_i == $past(cs_i)) |-> $stable(code_o)); // R5
    AST_CLEAN_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done_o && status_o == 2'd0) |-> (err_byte_o == '0 && err_bit_o == '0)); // R7
    AST_CODEERR_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done_o && status_o == 2'd2) |-> (err_byte_o == '0 && err_bit_o == '0)); // R9
endmodule

bind nand_ecc1_engine nand_ecc1_engine_chk #(
    .CS_W   (CS_W),
    .BI_W   (BI_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs_i),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .chk_i      (chk_i),
    .code_o     (code_o),
    .chk_done_o (chk_done_o),
    .status_o   (status_o),
    .err_byte_o (err_byte_o),
    .err_bit_o  (err_bit_o)
);

// File: tb/nand_ecc1_engine_bench.sv
module nand_ecc1_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cs_i = '0;
    logic        start_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        chk_i = 1'b0;
    logic [23:0] stored_code_i = '0;
    logic [23:0] code_o;
    logic        chk_done_o;
    logic [1:0]  status_o;
    logic [8:0]  err_byte_o;
    logic [2:0]  err_bit_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0] mem_a [512];
    logic [7:0] mem_b [512];

    always #4 clk = ~clk;

    nand_ecc1_engine u_nand_ecc1_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_i          (cs_i),
        .start_i       (start_i),
        .byte_vld_i    (byte_vld_i),
        .byte_i        (byte_i),
        .chk_i         (chk_i),
        .stored_code_i (stored_code_i),
        .code_o        (code_o),
        .chk_done_o    (chk_done_o),
        .status_o      (status_o),
        .err_byte_o    (err_byte_o),
        .err_bit_o     (err_bit_o)
    );

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_code(input logic [7:0] m [512]);
        logic [11:0] hi = '0;
        logic [11:0] lo = '0;
        for (int i = 0; i < 512; i++)
            for (int b = 0; b < 8; b++)
                if (m[i][b]) begin
                    hi ^= {9'(i), 3'(b)};
                    lo ^= ~{9'(i), 3'(b)};
                end
        return ~{hi, lo};
    endfunction

    task automatic fill(input int seed, output logic [7:0] m [512]);
        for (int i = 0; i < 512; i++) m[i] = 8'((i * 37 + seed) ^ (i >> 3));
    endtask

    task automatic do_start(input logic [1:0] cs);
        @(negedge clk);
        cs_i = cs; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic feed(input logic [1:0] cs, input logic [7:0] m [512],
                        input int first, input int last);
        for (int i = first; i <= last; i++) begin
            @(negedge clk);
            cs_i = cs; byte_vld_i = 1'b1; byte_i = m[i];
        end
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    task automatic run_check(input logic [1:0] cs, input logic [23:0] stored,
                             input string req, input logic [1:0] exp_st,
                             input logic [8:0] exp_byte, input logic [2:0] exp_bit);
        @(negedge clk);
        cs_i = cs; stored_code_i = stored; chk_i = 1'b1;
        @(negedge clk);
        chk_i = 1'b0;
        expect_eq(req, "done", 32'(chk_done_o), 32'd1);
        expect_eq(req, "status", 32'(status_o), 32'(exp_st));
        expect_eq(req, "byte", 32'(err_byte_o), 32'(exp_byte));
        expect_eq(req, "bit", 32'(err_bit_o), 32'(exp_bit));
        @(negedge clk);
        expect_eq("R6", "done pulse width", 32'(chk_done_o), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_eq("R1", "reset code", 32'(code_o), 32'hFFFFFF);
        expect_eq("R1", "reset done", 32'(chk_done_o), 32'd0);
    endtask

    task automatic t_erased();
        for (int i = 0; i < 512; i++) mem_a[i] = 8'hFF;
        do_start(2'd0);
        feed(2'd0, mem_a, 0, 511);
        expect_eq("R2", "erased code", 32'(code_o), 32'hFFFFFF);
        run_check(2'd0, 24'hFFFFFF, "R7", 2'd0, 9'd0, 3'd0);
    endtask

    task automatic t_pattern();
        logic [23:0] good;
        fill(11, mem_a);
        good = ref_code(mem_a);
        do_start(2'd1);
        feed(2'd1, mem_a, 0, 511);
        expect_eq("R2", "pattern code", 32'(code_o), 32'(good));
        run_check(2'd1, good, "R7", 2'd0, 9'd0, 3'd0);
    endtask

    task automatic t_data_err(input int idx, input int bitn);
        logic [23:0] good;
        fill(23 + idx, mem_a);
        good = ref_code(mem_a);
        mem_a[idx][bitn] = ~mem_a[idx][bitn];
        do_start(2'd1);
        feed(2'd1, mem_a, 0, 511);
        run_check(2'd1, good, "R8", 2'd1, 9'(idx), 3'(bitn));
    endtask

    task automatic t_code_err(input int bitn);
        logic [23:0] good;
        fill(5, mem_a);
        good = ref_code(mem_a);
        do_start(2'd2);
        feed(2'd2, mem_a, 0, 511);
        run_check(2'd2, good ^ (24'd1 << bitn), "R9", 2'd2, 9'd0, 3'd0);
    endtask

    task automatic t_uncorr();
        logic [23:0] good;
        fill(77, mem_a);
        good = ref_code(mem_a);
        mem_a[10][1] = ~mem_a[10][1];
        mem_a[400][6] = ~mem_a[400][6];
        do_start(2'd3);
        feed(2'd3, mem_a, 0, 511);
        run_check(2'd3, good, "R10", 2'd3, 9'd0, 3'd0);
    endtask

    task automatic t_contexts();
        fill(3, mem_a);
        fill(91, mem_b);
        do_start(2'd2);
        do_start(2'd3);
        feed(2'd2, mem_a, 0, 99);
        feed(2'd3, mem_b, 0, 511);
        feed(2'd2, mem_a, 100, 511);
        @(negedge clk);
        cs_i = 2'd2;
        @(negedge clk);
        expect_eq("R5", "split context code", 32'(code_o), 32'(ref_code(mem_a)));
        cs_i = 2'd3;
        @(negedge clk);
        expect_eq("R5", "other context code", 32'(code_o), 32'(ref_code(mem_b)));
    endtask

    task automatic t_overflow();
        fill(44, mem_a);
        do_start(2'd0);
        feed(2'd0, mem_a, 0, 511);
        for (int i = 0; i < 4; i++) mem_b[i] = 8'hA5;
        feed(2'd0, mem_b, 0, 3);
        expect_eq("R3", "bytes past chunk ignored", 32'(code_o), 32'(ref_code(mem_a)));
    endtask

    task automatic t_start_clear();
        fill(8, mem_a);
        do_start(2'd0);
        feed(2'd0, mem_a, 0, 20);
        @(negedge clk);
        cs_i = 2'd0; start_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'hFF;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
        expect_eq("R4", "cleared code", 32'(code_o), 32'hFFFFFF);
        mem_b[0] = 8'h01;
        feed(2'd0, mem_b, 0, 0);
        expect_eq("R4", "index restarts at zero", 32'(code_o), 32'hFFF000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_erased();
        t_pattern();
        t_data_err(300, 5);
        t_data_err(0, 0);
        t_data_err(511, 7);
        t_code_err(17);
        t_code_err(0);
        t_uncorr();
        t_contexts();
        t_overflow();
        t_start_clear();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule